// File: doc/BRIEF.md
# GPS Sentence Field Extractor

This block sits behind a serial receiver that delivers one 8-bit ASCII character at a time from a GPS module. The characters arrive at 9600 baud, 8 data bits, no parity, one stop bit. The block watches the character stream for sentences whose identifier ends in `RMC` or `GGA`. It ignores every other sentence type and does not verify checksums.

Inside an accepted sentence it counts commas to work out which field the current character belongs to. It keeps only the characters of time, latitude, longitude (each with its hemisphere letter), speed and date. Each character is written straight into its fixed slot of a 43-byte record in a byte-wide shared memory with a 12-bit address, so the memory holds at most 95 records.

A record is committed when its sentence terminates. A download controller can halt every write with a stop input, and it reads how many records are complete from a count output.

Top module: `nmea_field_extractor`

## Requirements
- R1: After reset, `mem_we`, `rec_valid` and `got_fix` are 0 and `rec_count` is 0.
- R2: Characters outside a sentence are discarded. A sentence is opened by `$` (0x24). A sentence whose identifier field (the text between `$` and the first `,` 0x2C) does not contain the consecutive letters R,M,C or G,G,A causes no write and no commit.
- R3: `got_fix` goes to 1 on the cycle after the identifier field shows consecutive `R` (0x52), `M` (0x4D), `C` (0x43) or `G` (0x47), `G`, `A` (0x41). It stays 1 until reset. No write ever happens while it is 0.
- R4: In an RMC sentence (fields numbered from 1 after the identifier), record slots are filled as follows:
  - field 1 goes to offsets 0..9;
  - field 3 goes to 10..18;
  - field 4 goes to 19;
  - field 5 goes to 20..29;
  - field 6 goes to 30;
  - field 7 goes to 31..36;
  - field 9 goes to 37..42.
  
  Fields 2, 8 and above 9 are not stored.
- R5: In a GGA sentence, fields 1..5 go to the time, latitude, latitude-hemisphere, longitude and longitude-hemisphere slots used in R4. The speed and date slots are not written.
- R6: The k-th character (from 0) of a field is written to `rec_count*43 + slot offset + k`. The write happens with `mem_we` high on the cycle after the character is accepted.
- R7: Characters beyond a slot's width are dropped.
- R8: `*` (0x2A) or CR (0x0D) ends a sentence. If the sentence's record is still open, `rec_valid` pulses for one cycle on the cycle after the terminator, and `rec_count` rises by one in that same cycle.
- R9: A `$` inside a sentence abandons the open record without a commit. The next record reuses the same base address.
- R10: While `stop_req` is high, nothing is written and nothing is committed. A record that is open on any cycle with `stop_req` high is discarded.
- R11: Once `rec_count` reaches 95, identifiers open no record and cause no writes, and the count stays at 95.
- R12: `in_byte` has no effect on any cycle where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A character is present on `in_byte` this cycle |
| in_byte | input | 8 | ASCII character from the serial receiver |
| stop_req | input | 1 | Download side requests all writing to halt |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| rec_valid | output | 1 | One-cycle pulse when a record is committed |
| rec_count | output | 7 | Number of committed records |
| got_fix | output | 1 | Sticky flag: a wanted identifier has been seen |

## Verification
The bench aims at the corners where a positional parser most often slips:
- A field longer than its slot. A design without truncation would overwrite the neighbouring latitude slot.
- A `$` arriving mid-sentence. A design that kept the open record would commit a half-filled record and shift every later base address.
- A stop pulse that rises and falls inside a sentence. A design that only gated writes would still commit the damaged record.
- Memory filled to the 95th record. An off-by-one capacity test would either write past the last whole record or refuse the last one.

A foreign sentence type and bytes presented with `in_valid` low are also sent, and each must leave every output untouched.

// File: rtl/nmea_xtr_pkg.sv
package nmea_xtr_pkg;

  localparam int REC_BYTES = 43;
  localparam int FNO_W     = 4;
  localparam int CNO_W     = 4;

  localparam logic [7:0] CH_DOLLAR = 8'h24;
  localparam logic [7:0] CH_COMMA  = 8'h2C;
  localparam logic [7:0] CH_STAR   = 8'h2A;
  localparam logic [7:0] CH_CR     = 8'h0D;

  typedef enum logic [1:0] {SK_NONE, SK_RMC, SK_GGA} sent_kind_e;
  typedef enum logic [1:0] {PH_WAIT, PH_ID, PH_FIELDS} phase_e;
  typedef enum logic [2:0] {
    IT_TIME, IT_LAT, IT_LATH, IT_LON, IT_LONH, IT_SPD, IT_DATE, IT_NONE
  } item_e;

  typedef struct packed {
    logic       hit;
    logic [5:0] off;
    logic [3:0] width;
  } slot_t;

  function automatic int cnt_w(int aw);
    return $clog2(((1 << aw) / REC_BYTES) + 1);
  endfunction

  // Identifier suffix match on the last three characters.
  function automatic sent_kind_e id_kind(logic [7:0] c2, logic [7:0] c1, logic [7:0] c0);
    if (c2 == 8'h52 && c1 == 8'h4D && c0 == 8'h43) return SK_RMC;
    if (c2 == 8'h47 && c1 == 8'h47 && c0 == 8'h41) return SK_GGA;
    return SK_NONE;
  endfunction

  // Which record item a field number carries, per sentence kind.
  function automatic item_e item_of(sent_kind_e k, logic [FNO_W-1:0] f);
    item_e it;
    it = IT_NONE;
    if (k == SK_RMC) begin
      case (f)
        4'd1: it = IT_TIME;
        4'd3: it = IT_LAT;
        4'd4: it = IT_LATH;
        4'd5: it = IT_LON;
        4'd6: it = IT_LONH;
        4'd7: it = IT_SPD;
        4'd9: it = IT_DATE;
        default: it = IT_NONE;
      endcase
    end else if (k == SK_GGA) begin
      case (f)
        4'd1: it = IT_TIME;
        4'd2: it = IT_LAT;
        4'd3: it = IT_LATH;
        4'd4: it = IT_LON;
        4'd5: it = IT_LONH;
        default: it = IT_NONE;
      endcase
    end
    return it;
  endfunction

  // Record layout: offset and width of each slot.
  function automatic slot_t slot_of(sent_kind_e k, logic [FNO_W-1:0] f);
    slot_t s;
    s = '{hit: 1'b1, off: 6'd0, width: 4'd0};
    case (item_of(k, f))
      IT_TIME: begin s.off = 6'd0;  s.width = 4'd10; end
      IT_LAT:  begin s.off = 6'd10; s.width = 4'd9;  end
      IT_LATH: begin s.off = 6'd19; s.width = 4'd1;  end
      IT_LON:  begin s.off = 6'd20; s.width = 4'd10; end
      IT_LONH: begin s.off = 6'd30; s.width = 4'd1;  end
      IT_SPD:  begin s.off = 6'd31; s.width = 4'd6;  end
      IT_DATE: begin s.off = 6'd37; s.width = 4'd6;  end
      default: s.hit = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nmea_tokenizer.sv
module nmea_tokenizer
  import nmea_xtr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             ev_start,
  output logic             ev_hit,
  output logic             ev_char,
  output logic             ev_end,
  output logic             ev_seal,
  output sent_kind_e       kind,
  output sent_kind_e       hit_kind,
  output logic [FNO_W-1:0] field_no,
  output logic [CNO_W-1:0] char_no
);

  phase_e     phase;
  logic [7:0] c1, c2;
  logic       is_dollar, is_term, is_comma, is_plain;

  always_comb begin
    is_dollar = in_valid && (in_byte == CH_DOLLAR);
    is_term   = in_valid && (in_byte == CH_STAR || in_byte == CH_CR);
    is_comma  = in_valid && (in_byte == CH_COMMA);
    is_plain  = in_valid && !is_dollar && !is_term && !is_comma;
    hit_kind  = id_kind(c2, c1, in_byte);
    ev_start  = is_dollar;
    ev_end    = is_term;
    ev_seal   = is_term && (phase == PH_FIELDS);
    ev_hit    = is_plain && (phase == PH_ID) && (kind == SK_NONE) && (hit_kind != SK_NONE);
    ev_char   = is_plain && (phase == PH_FIELDS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_WAIT;
      kind     <= SK_NONE;
      c1       <= '0;
      c2       <= '0;
      field_no <= '0;
      char_no  <= '0;
    end else if (in_valid) begin
      if (is_dollar) begin
        phase    <= PH_ID;
        kind     <= SK_NONE;
        c1       <= '0;
        c2       <= '0;
        field_no <= '0;
        char_no  <= '0;
      end else if (is_term) begin
        phase <= PH_WAIT;
        kind  <= SK_NONE;
      end else begin
        case (phase)
          PH_ID: begin
            if (is_comma) begin
              phase    <= (kind != SK_NONE) ? PH_FIELDS : PH_WAIT;
              field_no <= FNO_W'(1);
              char_no  <= '0;
            end else begin
              c2 <= c1;
              c1 <= in_byte;
              if (ev_hit) kind <= hit_kind;
            end
          end
          PH_FIELDS: begin
            if (is_comma) begin
              if (field_no != '1) field_no <= field_no + FNO_W'(1);
              char_no <= '0;
            end else if (char_no != '1) begin
              char_no <= char_no + CNO_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/nmea_rec_store.sv
module nmea_rec_store
  import nmea_xtr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic [7:0]        in_byte,
  input  logic              ev_start,
  input  logic              ev_hit,
  input  logic              ev_char,
  input  logic              ev_end,
  input  logic              ev_seal,
  input  sent_kind_e        kind,
  input  logic [FNO_W-1:0]  field_no,
  input  logic [CNO_W-1:0]  char_no,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              rec_valid,
  output logic [cnt_w(ADDR_W)-1:0] rec_count,
  output logic              got_fix,
  output logic              store_ok,
  output logic              rec_open
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int MAX_RECS = DEPTH / REC_BYTES;
  localparam int CNT_W    = cnt_w(ADDR_W);

  logic [ADDR_W-1:0] rec_base;
  logic [ADDR_W-1:0] byte_addr;
  slot_t             slot;
  logic              room;

  always_comb begin
    slot      = slot_of(kind, field_no);
    room      = rec_count < CNT_W'(MAX_RECS);
    store_ok  = ev_char && rec_open && !stop_req && slot.hit &&
                (char_no < slot.width);
    byte_addr = rec_base + ADDR_W'(slot.off) + ADDR_W'(char_no);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rec_valid <= 1'b0;
      rec_count <= '0;
      rec_base  <= '0;
      rec_open  <= 1'b0;
      got_fix   <= 1'b0;
    end else begin
      mem_we    <= store_ok;
      rec_valid <= 1'b0;
      if (store_ok) begin
        mem_addr  <= byte_addr;
        mem_wdata <= in_byte;
      end
      if (ev_hit) got_fix <= 1'b1;
      if (stop_req) begin
        rec_open <= 1'b0;
      end else if (ev_seal && rec_open) begin
        rec_base  <= rec_base + ADDR_W'(REC_BYTES);
        rec_count <= rec_count + CNT_W'(1);
        rec_valid <= 1'b1;
        rec_open  <= 1'b0;
      end else if (ev_end || ev_start) begin
        rec_open <= 1'b0;
      end else if (ev_hit && room) begin
        rec_open <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nmea_field_extractor.sv
module nmea_field_extractor
  import nmea_xtr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              stop_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              rec_valid,
  output logic [nmea_xtr_pkg::cnt_w(ADDR_W)-1:0] rec_count,
  output logic              got_fix
);

  logic             ev_start, ev_hit, ev_char, ev_end, ev_seal;
  sent_kind_e       kind, hit_kind;
  logic [FNO_W-1:0] field_no;
  logic [CNO_W-1:0] char_no;
  logic             store_ok, rec_open;

  nmea_tokenizer u_tok (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .ev_start (ev_start),
    .ev_hit   (ev_hit),
    .ev_char  (ev_char),
    .ev_end   (ev_end),
    .ev_seal  (ev_seal),
    .kind     (kind),
    .hit_kind (hit_kind),
    .field_no (field_no),
    .char_no  (char_no)
  );

  nmea_rec_store #(.ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_req  (stop_req),
    .in_byte   (in_byte),
    .ev_start  (ev_start),
    .ev_hit    (ev_hit),
    .ev_char   (ev_char),
    .ev_end    (ev_end),
    .ev_seal   (ev_seal),
    .kind      (kind),
    .field_no  (field_no),
    .char_no   (char_no),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rec_valid (rec_valid),
    .rec_count (rec_count),
    .got_fix   (got_fix),
    .store_ok  (store_ok),
    .rec_open  (rec_open)
  );

endmodule

// File: rtl/nmea_field_extractor_chk.sv
module nmea_field_extractor_chk
  import nmea_xtr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_req,
  input logic              ev_hit,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rec_valid,
  input logic [cnt_w(ADDR_W)-1:0] rec_count,
  input logic              got_fix
);

  localparam int MAX_RECS = (1 << ADDR_W) / REC_BYTES;
  localparam int CNT_W    = cnt_w(ADDR_W);

  // R3: the flag never drops once set
  a_r3_fix_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    got_fix |=> got_fix);

  // R3: an identifier hit raises the flag on the next cycle
  a_r3_hit_sets_fix: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> got_fix);

  // R3: no write before a wanted identifier was seen
  a_r3_write_needs_fix: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> got_fix);

  // R6: every write lands inside the record selected by the count
  a_r6_addr_in_rec: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(mem_addr) >= int'(rec_count) * REC_BYTES &&
                int'(mem_addr) <  int'(rec_count) * REC_BYTES + REC_BYTES));

  // R8: a commit advances the count by exactly one
  a_r8_commit_step: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_count == CNT_W'($past(rec_count) + 1'b1));

  // R8: the count changes only with a commit pulse
  a_r8_count_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |-> $stable(rec_count));

  // R10: stop blocks both writes and commits on the following cycle
  a_r10_stop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !mem_we);
  a_r10_stop_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !rec_valid);

  // R11: never more records than whole slots in the memory
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rec_count) <= MAX_RECS);

endmodule

bind nmea_field_extractor nmea_field_extractor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_req  (stop_req),
  .ev_hit    (ev_hit),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .rec_valid (rec_valid),
  .rec_count (rec_count),
  .got_fix   (got_fix)
);

// File: tb/nmea_field_extractor_test.sv
module nmea_field_extractor_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h24;
  logic        stop_req = 1'b0;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        rec_valid;
  logic [6:0]  rec_count;
  logic        got_fix;

  always #4 clk = ~clk;

  nmea_field_extractor uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .stop_req(stop_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rec_valid(rec_valid), .rec_count(rec_count),
    .got_fix(got_fix)
  );

  int ncmp = 0;
  int nbad = 0;
  int wr_seen = 0;
  byte unsigned bmem [4096];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ncmp++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_phase;   // 0 outside, 1 identifier, 2 data fields
  int m_kind;    // 0 none, 1 RMC, 2 GGA
  int m_fld, m_chr, m_cnt;
  bit m_open, m_fix;
  int idq[$];
  bit e_we, e_rv;
  int e_addr, e_data;
  int offs [7] = '{0, 10, 19, 20, 30, 31, 37};
  int wids [7] = '{10, 9, 1, 10, 1, 6, 6};

  function automatic int m_item(int k, int f);
    if (k == 1) begin
      case (f) 1: return 0; 3: return 1; 4: return 2; 5: return 3;
               6: return 4; 7: return 5; 9: return 6; default: return -1; endcase
    end
    if (k == 2) begin
      case (f) 1: return 0; 2: return 1; 3: return 2; 4: return 3;
               5: return 4; default: return -1; endcase
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_kind = 0; m_fld = 0; m_chr = 0; m_cnt = 0;
      m_open = 0; m_fix = 0; e_we = 0; e_rv = 0; e_addr = 0; e_data = 0;
      idq.delete();
    end else begin
      e_we = 0; e_rv = 0;
      if (in_valid) begin
        int b;
        b = int'(in_byte);
        if (b == 8'h24) begin
          m_open = 0; m_phase = 1; m_kind = 0; m_fld = 0; m_chr = 0;
          idq.delete();
        end else if (b == 8'h2A || b == 8'h0D) begin
          if (m_phase == 2 && m_open && !stop_req) begin
            m_cnt++; e_rv = 1;
          end
          m_open = 0; m_phase = 0; m_kind = 0;
        end else if (m_phase == 1) begin
          if (b == 8'h2C) begin
            m_phase = (m_kind != 0) ? 2 : 0;
            m_fld = 1; m_chr = 0;
          end else begin
            int n;
            idq.push_back(b);
            n = idq.size();
            if (m_kind == 0 && n >= 3) begin
              if (idq[n-3] == 8'h52 && idq[n-2] == 8'h4D && idq[n-1] == 8'h43) m_kind = 1;
              else if (idq[n-3] == 8'h47 && idq[n-2] == 8'h47 && idq[n-1] == 8'h41) m_kind = 2;
              if (m_kind != 0) begin
                m_fix = 1;
                if (!stop_req && m_cnt < 95) m_open = 1;
              end
            end
          end
        end else if (m_phase == 2) begin
          if (b == 8'h2C) begin
            if (m_fld < 15) m_fld++;
            m_chr = 0;
          end else begin
            int it;
            it = m_item(m_kind, m_fld);
            if (m_open && !stop_req && it >= 0 && m_chr < wids[it]) begin
              e_we = 1; e_addr = m_cnt * 43 + offs[it] + m_chr; e_data = b;
            end
            if (m_chr < 15) m_chr++;
          end
        end
      end
      if (stop_req) m_open = 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      chk(mem_we == e_we, "R6 write strobe", int'(mem_we), int'(e_we));
      if (e_we && mem_we) begin
        chk(int'(mem_addr) == e_addr, "R6 write address", int'(mem_addr), e_addr);
        chk(int'(mem_wdata) == e_data, "R4 write data", int'(mem_wdata), e_data);
      end
      chk(rec_valid == e_rv, "R8 commit pulse", int'(rec_valid), int'(e_rv));
      chk(int'(rec_count) == m_cnt, "R8 record count", int'(rec_count), m_cnt);
      chk(got_fix == m_fix, "R3 fix flag", int'(got_fix), int'(m_fix));
      if (mem_we) begin
        bmem[mem_addr] = mem_wdata;
        wr_seen++;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_byte(input byte unsigned b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h24;   // R12: a '$' held with in_valid low must do nothing
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic settle;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic expect_str(input int base, input string s, input string tag);
    for (int i = 0; i < s.len(); i++)
      chk(bmem[base + i] == s[i], tag, int'(bmem[base + i]), int'(s[i]));
  endtask

  bit finished = 0;

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    ncmp++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int w0;
    for (int i = 0; i < 4096; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_we == 1'b0, "R1 mem_we at reset", int'(mem_we), 0);
    chk(rec_valid == 1'b0, "R1 rec_valid at reset", int'(rec_valid), 0);
    chk(rec_count == 7'd0, "R1 rec_count at reset", int'(rec_count), 0);
    chk(got_fix == 1'b0, "R1 got_fix at reset", int'(got_fix), 0);
    rst_n = 1'b1;

    // R2: identifier letters outside a sentence are discarded
    send_str("GPRMC,123456.000,A,*\r\n");
    // R2: foreign sentence type
    send_str("$GPGSA,A,3,04,05,,1.8*1D\r\n");
    settle();
    chk(wr_seen == 0, "R2 no writes before an accepted sentence", wr_seen, 0);
    chk(got_fix == 1'b0, "R2 flag still clear", int'(got_fix), 0);
    chk(rec_count == 7'd0, "R2 no commit", int'(rec_count), 0);

    // R4: full RMC sentence into record 0
    send_str("$GPRMC,161229.487,A,3723.2475,N,12158.3416,W,0.13,309.62,120598,,*10\r\n");
    settle();
    chk(got_fix == 1'b1, "R3 flag set by RMC", int'(got_fix), 1);
    chk(rec_count == 7'd1, "R8 count after RMC", int'(rec_count), 1);
    expect_str(0,  "161229.487", "R4 time slot");
    expect_str(10, "3723.2475N12158.3416W0.13", "R4 position and speed slots");
    chk(bmem[35] == 8'h00, "R4 course not stored", int'(bmem[35]), 0);
    expect_str(37, "120598", "R4 date slot");

    // R5/R6: GGA sentence into record 1
    send_str("$GPGGA,161229.487,3723.2475,N,12158.3416,W,1,07,1.0,9.0,M,,,,0000*18\r\n");
    settle();
    expect_str(43, "161229.4873723.2475N12158.3416W", "R5 GGA slots at base 43");
    chk(bmem[43 + 31] == 8'h00, "R5 GGA writes no speed", int'(bmem[74]), 0);
    chk(bmem[43 + 37] == 8'h00, "R5 GGA writes no date", int'(bmem[80]), 0);

    // R7: over-long time field is truncated, record 2 at base 86
    send_str("$GPRMC,1612294870AB,A,1111.2222,S,*\r");
    settle();
    expect_str(86, "16122948701111.2222S", "R7 truncated time then latitude");

    // R9: '$' mid-sentence abandons the open record
    send_str("$GPRMC,999999.000,A,$GPGGA,010203.000,*\r\n");
    settle();
    chk(rec_count == 7'd4, "R9 only the second sentence committed", int'(rec_count), 4);
    expect_str(129, "010203.000", "R9 reused base after abort");

    // R10: stop pulse inside a sentence drops the record
    send_str("$GPRMC,222222.000,A,");
    stop_req = 1'b1;
    w0 = wr_seen;
    send_str("3333.4444");
    chk(wr_seen == w0, "R10 no writes during stop", wr_seen - w0, 0);
    stop_req = 1'b0;
    send_str(",N,*\r\n");
    settle();
    chk(rec_count == 7'd4, "R10 dropped record not committed", int'(rec_count), 4);
    chk(bmem[172 + 19] == 8'h00, "R10 closed record writes nothing", int'(bmem[191]), 0);
    // R10: stop held for a whole sentence
    stop_req = 1'b1;
    w0 = wr_seen;
    send_str("$GPRMC,1,A,2,N,*\r\n");
    stop_req = 1'b0;
    settle();
    chk(wr_seen == w0, "R10 no writes while stop held", wr_seen - w0, 0);
    chk(rec_count == 7'd4, "R10 no commit while stop held", int'(rec_count), 4);

    // R11: fill up to capacity
    while (rec_count < 7'd95) begin
      send_str("$GPRMC,1,A,2*\r");
      #1;
    end
    settle();
    chk(rec_count == 7'd95, "R11 memory full at 95", int'(rec_count), 95);
    expect_str(94 * 43, "1", "R11 last record time");
    expect_str(94 * 43 + 10, "2", "R11 last record latitude");
    w0 = wr_seen;
    send_str("$GPGGA,5,6,N,7,E,*\r");
    settle();
    chk(wr_seen == w0, "R11 no write when full", wr_seen - w0, 0);
    chk(rec_count == 7'd95, "R11 count holds when full", int'(rec_count), 95);
    chk(got_fix == 1'b1, "R3 flag stays set", int'(got_fix), 1);

    finish_run();
  end

endmodule